// File: doc/BRIEF.md
# Streaming Square-Root Pulse Counter

This block follows the square root of the number of count pulses seen since the last start, and updates the result with every pulse as it arrives. It uses no multiplier and no iterative search. The block has two parts. The first is a root register whose least significant bit is worth one half. The second is a span down-counter. The root register advances only on pulses that arrive while the span counter is empty, and on each such pulse the span counter is refilled from the current root. The gaps between root increments therefore grow together with the root.

A start input clears both registers and arms a first-pulse flag. The first pulse after a start adds two half-units, so the unit bit becomes 1 and the half bit stays 0. Every later increment adds one half-unit. The result is exact at every perfect square, and otherwise lies within half a unit of the true root. The block is fully synchronous. Pulses are sampled as a per-cycle enable.

Top module: `sqroot_pulse_counter`

## Requirements
- R1: After reset or after a cycle with `start_i` high, `root_o` is 0 and `zero_o` is 1.
- R2: The first pulse after reset or start sets `root_o` to 2 (bit 1 = one unit, bit 0 = one half). No later pulse adds 2.
- R3: A pulse taken while `zero_o` is 0 leaves `root_o` unchanged.
- R4: A pulse taken while `zero_o` is 1, other than the first pulse, increments `root_o` by exactly 1.
- R5: A pulse taken while `zero_o` is 1 loads the span counter with the previous `root_o` shifted right by one. `zero_o` then reads 1 only if that value is 0.
- R6: A pulse taken while `zero_o` is 0 decrements the span counter by one. `zero_o` is 1 exactly when the span counter is 0.
- R7: A cycle with neither `pulse_i` nor `start_i` changes neither `root_o` nor `zero_o`.
- R8: After n pulses, let k be the largest integer with k*k <= n. `root_o` is 2k if n < k*k+k, and 2k+1 otherwise. At n = k*k it is exactly 2k.
- R9: When `start_i` and `pulse_i` are high in the same cycle, the start wins and the pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous clear; arms the first-pulse flag |
| pulse_i | input | 1 | Count pulse, one per high cycle |
| root_o | output | ROOT_W | Root estimate, LSB worth one half |
| zero_o | output | 1 | Span counter empty; the next pulse advances the root |

## Verification
A run of 255 back-to-back pulses compares the root and the empty flag with closed-form values after every pulse. This separates the increments at perfect squares from the half-unit increments at k*k+k, and separates both from the countdown pulses in between. Idle cycles between pulses show that the state holds when no pulse is present. A start on its own, and a start together with a pulse, show the clear and its priority. The short sequence that follows a restart shows the double first step, and then a pulse that is gated because the span counter is not empty.

// File: rtl/sqrc_pkg.sv
package sqrc_pkg;
  localparam int unsigned SQRC_ROOT_W_DEF = 8;

  typedef enum logic [1:0] {
    SPAN_HOLD = 2'd0,
    SPAN_LOAD = 2'd1,
    SPAN_DOWN = 2'd2,
    SPAN_CLR  = 2'd3
  } span_op_e;
endpackage

// File: rtl/sqrc_start_flag.sv
module sqrc_start_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic pulse_i,
  output logic first_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       first_o <= 1'b1;
    else if (start_i) first_o <= 1'b1;
    else if (pulse_i) first_o <= 1'b0;
  end
endmodule

// File: rtl/sqrc_span_counter.sv
module sqrc_span_counter
  import sqrc_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  span_op_e         op_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  function automatic logic [CNT_W-1:0] span_next(
    input span_op_e op, input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] rl);
    case (op)
      SPAN_LOAD: return rl;
      SPAN_DOWN: return cur - CNT_W'(1);
      SPAN_CLR:  return '0;
      default:   return cur;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt_nxt;
  assign cnt_nxt = span_next(op_i, cnt_o, reload_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      zero_o <= 1'b1;
    end else if (op_i != SPAN_HOLD) begin
      cnt_o  <= cnt_nxt;
      zero_o <= (cnt_nxt == '0);
    end
  end
endmodule

// File: rtl/sqrc_root_acc.sv
module sqrc_root_acc #(
  parameter int unsigned ROOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              first_i,
  output logic [ROOT_W-1:0] root_o
);
  function automatic logic [ROOT_W-1:0] root_step(
    input logic [ROOT_W-1:0] cur, input logic first);
    logic [ROOT_W-1:0] addend;
    addend = {{(ROOT_W-1){1'b0}}, first};
    return cur + addend + ROOT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       root_o <= '0;
    else if (clear_i) root_o <= '0;
    else if (step_i)  root_o <= root_step(root_o, first_i);
  end
endmodule

// File: rtl/sqroot_pulse_counter.sv
module sqroot_pulse_counter
  import sqrc_pkg::*;
#(
  parameter int unsigned ROOT_W = SQRC_ROOT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pulse_i,
  output logic [ROOT_W-1:0] root_o,
  output logic              zero_o
);
  localparam int unsigned CNT_W = ROOT_W - 1;

  logic             first_q;
  logic             zero_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_w;
  logic             pulse_ok;
  logic             inc_fire;
  logic             load_fire;
  logic             down_fire;
  span_op_e         span_op;

  assign pulse_ok  = pulse_i & ~start_i;
  assign inc_fire  = pulse_ok & zero_q;
  assign load_fire = inc_fire;
  assign down_fire = pulse_ok & ~zero_q;

  for (genvar s = 0; s < CNT_W; s++) begin : g_reload
    assign reload_w[s] = root_o[s+1];
  end

  always_comb begin
    if (start_i)        span_op = SPAN_CLR;
    else if (load_fire) span_op = SPAN_LOAD;
    else if (down_fire) span_op = SPAN_DOWN;
    else                span_op = SPAN_HOLD;
  end

  sqrc_start_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .pulse_i (pulse_i),
    .first_o (first_q)
  );

  sqrc_span_counter #(.CNT_W(CNT_W)) u_span (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (span_op),
    .reload_i (reload_w),
    .cnt_o    (cnt_q),
    .zero_o   (zero_q)
  );

  sqrc_root_acc #(.ROOT_W(ROOT_W)) u_root (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .step_i  (inc_fire),
    .first_i (first_q),
    .root_o  (root_o)
  );

  assign zero_o = zero_q;
endmodule

// File: rtl/sqroot_pulse_counter_chk.sv
module sqroot_pulse_counter_chk #(
  parameter int unsigned ROOT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              pulse_i,
  input logic [ROOT_W-1:0] root_o,
  input logic              zero_o,
  input logic [ROOT_W-2:0] cnt_q,
  input logic              first_q
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (root_o == '0) && zero_o && first_q); // R1

  AST_FIRST_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !start_i && first_q) |=> (root_o == ROOT_W'(2))); // R2

  AST_ROOT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !start_i && !zero_o) |=> $stable(root_o)); // R3

  AST_ROOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !start_i && zero_o && !first_q) |=>
      (root_o == ($past(root_o) + ROOT_W'(1)))); // R4

  AST_SPAN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !start_i && zero_o) |=> (cnt_q == $past(root_o[ROOT_W-1:1]))); // R5

  AST_SPAN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !start_i && !zero_o) |=> (cnt_q == ($past(cnt_q) - (ROOT_W-1)'(1)))); // R6

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (cnt_q == '0)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_i && !start_i) |=> ($stable(root_o) && $stable(zero_o))); // R7
endmodule

bind sqroot_pulse_counter sqroot_pulse_counter_chk #(.ROOT_W(ROOT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .pulse_i (pulse_i),
  .root_o  (root_o),
  .zero_o  (zero_o),
  .cnt_q   (cnt_q),
  .first_q (first_q)
);

// File: tb/sqroot_pulse_counter_test.sv
`timescale 1ns/1ps
module sqroot_pulse_counter_test;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         pulse_i = 1'b0;
  logic [W-1:0] root_o;
  logic         zero_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sqroot_pulse_counter #(.ROOT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pulse_i(pulse_i),
    .root_o(root_o), .zero_o(zero_o));

  // {pulse count, expected root}
  localparam logic [15:0] VEC [12] = '{
    {8'd1, 8'd2},  {8'd2, 8'd3},   {8'd3, 8'd3},   {8'd4, 8'd4},
    {8'd6, 8'd5},  {8'd9, 8'd6},   {8'd12, 8'd7},  {8'd16, 8'd8},
    {8'd25, 8'd10},{8'd30, 8'd11}, {8'd100, 8'd20},{8'd255, 8'd31}};

  function automatic int exp_root(input int n);
    int k = 0;
    if (n == 0) return 0;
    while ((k + 1) * (k + 1) <= n) k++;
    return (n >= k * k + k) ? 2 * k + 1 : 2 * k;
  endfunction

  function automatic bit exp_zero(input int n);
    int m = n + 1;
    for (int k = 1; k * k <= m; k++)
      if (k * k == m || k * k + k == m) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic one_pulse();
    @(negedge clk) pulse_i = 1'b1;
    @(negedge clk) pulse_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset root", root_o, 0);
    check("R1 reset zero", zero_o, 1);

    for (int n = 1; n <= 255; n++) begin
      one_pulse();
      check("R8 root trace", root_o, exp_root(n));
      check("R6 zero trace", zero_o, exp_zero(n));
      for (int v = 0; v < 12; v++)
        if (int'(VEC[v][15:8]) == n)
          check("R8 table", root_o, int'(VEC[v][7:0]));
    end

    // R7: idle cycles change nothing
    repeat (6) @(negedge clk);
    check("R7 idle root", root_o, 31);
    check("R7 idle zero", zero_o, exp_zero(255));

    // R1: start clears
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check("R1 start root", root_o, 0);
    check("R1 start zero", zero_o, 1);

    // R2: first pulse after start adds two half-units
    one_pulse();
    check("R2 first pulse root", root_o, 2);
    check("R5 zero after first", zero_o, 1);
    one_pulse();
    check("R4 second pulse root", root_o, 3);
    check("R5 reload nonzero", zero_o, 0);
    one_pulse();
    check("R3 gated pulse root", root_o, 3);
    check("R6 countdown to zero", zero_o, 1);

    // R9: start wins over pulse
    @(negedge clk) begin start_i = 1'b1; pulse_i = 1'b1; end
    @(negedge clk) begin start_i = 1'b0; pulse_i = 1'b0; end
    check("R9 start priority root", root_o, 0);
    check("R9 start priority zero", zero_o, 1);
    one_pulse();
    check("R2 first pulse after clash", root_o, 2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule